// File: doc/BRIEF.md
# Transport Sync Byte Frame Aligner

This block sits behind a convolutional decoder and receives its output one bit per valid cycle, most significant bit of each byte first. It searches every bit position for a periodic sync byte. Once the sync byte has appeared at the expected spacing often enough, it declares lock. While locked it emits aligned bytes, each with a start-of-block flag and a sync flag.

Two framing formats are supported. The format is chosen when a search is started. In format A, sync value 0x47 opens every 204-byte block and is passed to the output. In format B, sync value 0x1D precedes every 146-byte block, which gives a 147-byte period, and the sync byte is removed from the output. While locked, a run of missing sync bytes drops lock and the search starts again. A fail flag reports a search that has not locked within a programmable number of frame periods.

Top module: `tsa_aligner`

## Requirements
- R1: With `fmt_sel`=0 latched, the sync value is 0x47 at byte 0 of each 204-byte period. That byte is output with `byte_sob`=1, and also with `byte_sync`=1 when it matched.
- R2: With `fmt_sel`=1 latched, the sync value is 0x1D at byte 0 of each 147-byte period. That byte is never output, `byte_sync` stays 0, and byte 1 of each period carries `byte_sob`=1.
- R3: Lock is declared on the last bit of the third consecutive sync byte found one period apart, at any of the 8 bit offsets. Bytes are output only while locked, and the first byte output is the one after that third sync byte.
- R4: While locked, a sync position that does not match is still output in format A with `byte_sob`=1 and `byte_sync`=0. A matching sync resets the miss run. Lock drops on the last bit of the fourth consecutive miss, and a new search then relocks on three good sync bytes.
- R5: If `fail_limit` is nonzero and lock is not reached within `fail_limit` searched frame periods, counted in valid bits since the search began, `fail` rises on the last bit of that period. The search then halts (no lock, no bytes) until `start`. A `fail_limit` of 0 disables the fail flag.
- R6: A `start` pulse clears `fail` and `locked` in the next cycle, restarts the search and latches `fmt_sel`. A change of `fmt_sel` at any other time has no effect.
- R7: Cycles with `bit_vld`=0 are ignored. Bits are assembled most significant bit first.
- R8: `byte_vld` is a one-cycle pulse. `byte_sob` and `byte_sync` are high only with `byte_vld`. `locked` and `fail` are never high together.
- R9: After reset the block is idle, with `byte_vld`, `byte_sob`, `byte_sync`, `byte_out`, `locked` and `fail` all 0, until the first `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: begin a new search, latch format |
| fmt_sel | input | 1 | Format select, 0 = 204-byte/0x47, 1 = 147-byte/0x1D |
| fail_limit | input | LIMW | Searched frame periods allowed before fail, 0 = never |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | `bit_in` is valid this cycle |
| byte_out | output | 8 | Aligned output byte |
| byte_vld | output | 1 | `byte_out` valid pulse |
| byte_sob | output | 1 | Byte starts a code block |
| byte_sync | output | 1 | Byte is a matched sync byte |
| locked | output | 1 | Frame synchronization achieved |
| fail | output | 1 | Search gave up within the limit |

## Verification
The assertions assume that `start`, `bit_vld` and `bit_in` are known in every cycle after reset. They assume `start` is a pulse rather than a held level, so the fail-hold property refers only to cycles without `start`. The stimulus holds `bit_vld` low while `start` is pulsed. It also chooses payload bytes in the range 0x00 to 0x0F, and no 8-bit window across such bytes and either sync value equals a sync value. Because of this, lock and loss happen on exactly the sync byte the requirements name, and the expected byte streams are exact.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HUNT,
      ST_VERIFY,
      ST_LOCK,
      ST_FAIL
   } tsa_state_e;
endpackage

// File: rtl/tsa_window.sv
module tsa_window #(
   parameter int MSB_FIRST = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_in,
   input  logic       bit_vld,
   input  logic [7:0] pat,
   output logic [7:0] win_nx,
   output logic       hit_nx
);
   logic [7:0] win_q;

   generate
      if (MSB_FIRST != 0) begin : g_msb
         assign win_nx = {win_q[6:0], bit_in};
      end else begin : g_lsb
         assign win_nx = {bit_in, win_q[7:1]};
      end
   endgenerate

   assign hit_nx = (win_nx == pat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       win_q <= '0;
      else if (bit_vld) win_q <= win_nx;
   end
endmodule

// File: rtl/tsa_ctrl.sv
module tsa_ctrl
   import tsa_pkg::*;
#(
   parameter logic [7:0] A_SYNC      = 8'h47,
   parameter logic [7:0] B_SYNC      = 8'h1D,
   parameter int         A_LEN       = 204,
   parameter int         B_LEN       = 147,
   parameter int         LOCK_HITS   = 3,
   parameter int         LOSS_MISSES = 4,
   parameter int         LIMW        = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            fmt_sel,
   input  logic [LIMW-1:0] fail_limit,
   input  logic            bit_vld,
   input  logic            hit_nx,
   output logic [7:0]      pat,
   output logic            emit,
   output logic            emit_sob,
   output logic            emit_sync,
   output logic            locked,
   output logic            fail,
   output logic            mode_q
);
   localparam int MAXB = ((A_LEN > B_LEN) ? A_LEN : B_LEN) * 8;
   localparam int CW   = $clog2(MAXB);
   localparam int HW   = $clog2(LOCK_HITS + 1);
   localparam int MW   = $clog2(LOSS_MISSES + 1);

   tsa_state_e      st_q, st_d;
   logic [CW-1:0]   cnt_q, cnt_d, cnt_nx, sbit_q, sbit_d, sbit_nx, last;
   logic [HW-1:0]   hits_q, hits_d;
   logic [MW-1:0]   miss_q, miss_d;
   logic [LIMW-1:0] per_q, per_d;
   logic            mode_d;

   assign last    = mode_q ? CW'(B_LEN * 8 - 1) : CW'(A_LEN * 8 - 1);
   assign cnt_nx  = (cnt_q == last) ? '0 : cnt_q + 1'b1;
   assign sbit_nx = (sbit_q == last) ? '0 : sbit_q + 1'b1;
   assign pat     = mode_q ? B_SYNC : A_SYNC;

   always_comb begin
      st_d   = st_q;
      cnt_d  = cnt_q;
      hits_d = hits_q;
      miss_d = miss_q;
      sbit_d = sbit_q;
      per_d  = per_q;
      mode_d = mode_q;
      if (start) begin
         st_d   = ST_HUNT;
         mode_d = fmt_sel;
         cnt_d  = '0;
         hits_d = '0;
         miss_d = '0;
         sbit_d = '0;
         per_d  = '0;
      end else if (bit_vld) begin
         unique case (st_q)
            ST_HUNT: begin
               if (hit_nx) begin
                  st_d   = ST_VERIFY;
                  cnt_d  = '0;
                  hits_d = HW'(1);
               end
            end
            ST_VERIFY: begin
               cnt_d = cnt_nx;
               if (cnt_nx == '0) begin
                  if (!hit_nx) begin
                     st_d   = ST_HUNT;
                     hits_d = '0;
                  end else if (hits_q == HW'(LOCK_HITS - 1)) begin
                     st_d   = ST_LOCK;
                     miss_d = '0;
                  end else begin
                     hits_d = hits_q + 1'b1;
                  end
               end
            end
            ST_LOCK: begin
               cnt_d = cnt_nx;
               if (cnt_nx == '0) begin
                  if (hit_nx) begin
                     miss_d = '0;
                  end else if (miss_q == MW'(LOSS_MISSES - 1)) begin
                     st_d   = ST_HUNT;
                     miss_d = '0;
                     hits_d = '0;
                     sbit_d = '0;
                     per_d  = '0;
                  end else begin
                     miss_d = miss_q + 1'b1;
                  end
               end
            end
            default: ;
         endcase
         if ((st_q == ST_HUNT || st_q == ST_VERIFY) && st_d != ST_LOCK) begin
            sbit_d = sbit_nx;
            if (sbit_nx == '0) begin
               per_d = per_q + 1'b1;
               if (fail_limit != '0 && (per_q + LIMW'(1)) == fail_limit)
                  st_d = ST_FAIL;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         hits_q <= '0;
         miss_q <= '0;
         sbit_q <= '0;
         per_q  <= '0;
         mode_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         hits_q <= hits_d;
         miss_q <= miss_d;
         sbit_q <= sbit_d;
         per_q  <= per_d;
         mode_q <= mode_d;
      end
   end

   assign emit      = bit_vld && !start && (st_q == ST_LOCK) && (cnt_nx[2:0] == 3'd0)
                      && !(mode_q && cnt_nx == '0);
   assign emit_sob  = (cnt_nx == (mode_q ? CW'(8) : '0));
   assign emit_sync = (cnt_nx == '0) && hit_nx;
   assign locked    = (st_q == ST_LOCK);
   assign fail      = (st_q == ST_FAIL);
endmodule

// File: rtl/tsa_emit.sv
module tsa_emit (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       emit,
   input  logic       emit_sob,
   input  logic       emit_sync,
   input  logic [7:0] win_nx,
   output logic [7:0] byte_out,
   output logic       byte_vld,
   output logic       byte_sob,
   output logic       byte_sync
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_out  <= '0;
         byte_vld  <= 1'b0;
         byte_sob  <= 1'b0;
         byte_sync <= 1'b0;
      end else begin
         byte_vld  <= emit;
         byte_sob  <= emit && emit_sob;
         byte_sync <= emit && emit_sync;
         if (emit) byte_out <= win_nx;
      end
   end
endmodule

// File: rtl/tsa_aligner.sv
module tsa_aligner #(
   parameter logic [7:0] A_SYNC      = 8'h47,
   parameter logic [7:0] B_SYNC      = 8'h1D,
   parameter int         A_LEN       = 204,
   parameter int         B_LEN       = 147,
   parameter int         LOCK_HITS   = 3,
   parameter int         LOSS_MISSES = 4,
   parameter int         LIMW        = 8,
   parameter int         MSB_FIRST   = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            fmt_sel,
   input  logic [LIMW-1:0] fail_limit,
   input  logic            bit_in,
   input  logic            bit_vld,
   output logic [7:0]      byte_out,
   output logic            byte_vld,
   output logic            byte_sob,
   output logic            byte_sync,
   output logic            locked,
   output logic            fail
);
   generate
      if (LOCK_HITS < 2) begin : g_bad_hits
         $error("LOCK_HITS must be at least 2");
      end
      if (LOSS_MISSES < 1) begin : g_bad_miss
         $error("LOSS_MISSES must be at least 1");
      end
      if (A_LEN < 2 || B_LEN < 3) begin : g_bad_len
         $error("frame lengths too short");
      end
      if (LIMW < 1) begin : g_bad_limw
         $error("LIMW must be positive");
      end
   endgenerate

   logic [7:0] pat, win_nx;
   logic       hit_nx, emit, emit_sob, emit_sync, mode_q;

   tsa_window #(.MSB_FIRST(MSB_FIRST)) u_win (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
      .pat(pat), .win_nx(win_nx), .hit_nx(hit_nx)
   );

   tsa_ctrl #(
      .A_SYNC(A_SYNC), .B_SYNC(B_SYNC), .A_LEN(A_LEN), .B_LEN(B_LEN),
      .LOCK_HITS(LOCK_HITS), .LOSS_MISSES(LOSS_MISSES), .LIMW(LIMW)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .fmt_sel(fmt_sel),
      .fail_limit(fail_limit), .bit_vld(bit_vld), .hit_nx(hit_nx),
      .pat(pat), .emit(emit), .emit_sob(emit_sob), .emit_sync(emit_sync),
      .locked(locked), .fail(fail), .mode_q(mode_q)
   );

   tsa_emit u_emit (
      .clk(clk), .rst_n(rst_n), .emit(emit), .emit_sob(emit_sob),
      .emit_sync(emit_sync), .win_nx(win_nx), .byte_out(byte_out),
      .byte_vld(byte_vld), .byte_sob(byte_sob), .byte_sync(byte_sync)
   );
endmodule

// File: rtl/tsa_aligner_chk.sv
module tsa_aligner_chk #(
   parameter logic [7:0] A_SYNC = 8'h47
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       bit_vld,
   input logic [7:0] byte_out,
   input logic       byte_vld,
   input logic       byte_sob,
   input logic       byte_sync,
   input logic       locked,
   input logic       fail,
   input logic       mode_q
);
   // R3
   bytes_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> $past(locked));

   // R8
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);

   // R8
   flags_with_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_sob || byte_sync) |-> byte_vld);

   // R8
   lock_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(locked && fail));

   // R1
   sync_only_fmt_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_sync |-> (byte_sob && !mode_q && byte_out == A_SYNC));

   // R6
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!fail && !locked));

   // R5
   fail_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> fail);

   // R7
   lock_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(bit_vld));
endmodule

bind tsa_aligner tsa_aligner_chk #(.A_SYNC(A_SYNC)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .bit_vld(bit_vld),
   .byte_out(byte_out), .byte_vld(byte_vld), .byte_sob(byte_sob),
   .byte_sync(byte_sync), .locked(locked), .fail(fail), .mode_q(mode_q)
);

// File: tb/tb_tsa_aligner.sv
module tb_tsa_aligner;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       fmt_sel = 1'b0;
   logic [7:0] fail_limit = 8'd0;
   logic       bit_in = 1'b0;
   logic       bit_vld = 1'b0;
   logic [7:0] byte_out;
   logic       byte_vld, byte_sob, byte_sync, locked, fail;

   int vectors = 0;
   int errors = 0;
   int cyc = 0;
   bit gaps = 0;
   int bitn = 0;

   logic [7:0] rec_b [0:2047];
   logic       rec_s [0:2047];
   logic       rec_y [0:2047];
   int         rec_cnt = 0;

   always #5 clk = ~clk;

   tsa_aligner dut (
      .clk(clk), .rst_n(rst_n), .start(start), .fmt_sel(fmt_sel),
      .fail_limit(fail_limit), .bit_in(bit_in), .bit_vld(bit_vld),
      .byte_out(byte_out), .byte_vld(byte_vld), .byte_sob(byte_sob),
      .byte_sync(byte_sync), .locked(locked), .fail(fail)
   );

   always @(negedge clk) begin
      if (byte_vld && rec_cnt < 2048) begin
         rec_b[rec_cnt] = byte_out;
         rec_s[rec_cnt] = byte_sob;
         rec_y[rec_cnt] = byte_sync;
         rec_cnt = rec_cnt + 1;
      end
   end

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         vectors = vectors + 1;
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         summary();
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors = vectors + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pay(input int f, input int idx);
      return 8'((f + idx) & 15);
   endfunction

   task automatic idle();
      @(negedge clk);
      bit_vld = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      bit_in = b;
      bit_vld = 1'b1;
      bitn = bitn + 1;
      if (gaps && (bitn % 5) == 0) idle();
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic send_frame(input bit fb, input int f, input bit bad_sync);
      int len;
      len = fb ? 147 : 204;
      send_byte(bad_sync ? 8'h00 : (fb ? 8'h1D : 8'h47));
      for (int i = 1; i < len; i++) send_byte(pay(f, i));
   endtask

   task automatic do_start(input bit fb, input logic [7:0] lim);
      @(negedge clk);
      bit_vld = 1'b0;
      start = 1'b1;
      fmt_sel = fb;
      fail_limit = lim;
      @(negedge clk);
      start = 1'b0;
      // R6: fail and lock clear after start
      chk(!fail && !locked, "R6 start clear", {fail, locked}, 0);
   endtask

   task automatic t_reset();
      chk(byte_vld == 0 && locked == 0 && fail == 0 && byte_out == 0 &&
          byte_sob == 0 && byte_sync == 0, "R9 reset", {byte_out, locked, fail}, 0);
      repeat (20) @(negedge clk);
      chk(byte_vld == 0 && locked == 0, "R9 idle before start", locked, 0);
   endtask

   task automatic t_fmt_a();
      int bad, nsob, nsync, k;
      do_start(1'b0, 8'd0);
      fmt_sel = 1'b1; // R6: ignored after start
      rec_cnt = 0;
      for (int i = 0; i < 3; i++) send_bit(1'b0);
      send_frame(1'b0, 0, 1'b0);
      send_frame(1'b0, 1, 1'b0);
      idle();
      chk(locked == 0, "R3 no lock after two syncs", locked, 0);
      send_byte(8'h47);
      idle();
      chk(locked == 1, "R3 lock on third sync", locked, 1);
      for (int i = 1; i < 204; i++) send_byte(pay(2, i));
      send_frame(1'b0, 3, 1'b0);
      send_frame(1'b0, 4, 1'b0);
      idle(); idle();
      chk(rec_cnt == 611, "R3 byte count fmt A", rec_cnt, 611);
      chk(rec_b[0] == pay(2, 1) && rec_s[0] == 0, "R3 first byte after third sync",
          rec_b[0], pay(2, 1));
      bad = 0; nsob = 0; nsync = 0; k = 0;
      for (int f = 2; f <= 4; f++)
         for (int i = (f == 2) ? 1 : 0; i < 204; i++) begin
            if (k < rec_cnt) begin
               if (rec_b[k] != ((i == 0) ? 8'h47 : pay(f, i))) bad++;
               if (rec_s[k] != (i == 0)) bad++;
               if (rec_s[k]) nsob++;
               if (rec_y[k]) nsync++;
            end
            k++;
         end
      chk(bad == 0, "R1 byte stream fmt A (R7 msb first)", bad, 0);
      chk(nsob == 2 && nsync == 2, "R1 sync passed with sob", nsob * 10 + nsync, 22);
      chk(locked == 1, "R6 fmt_sel change ignored", locked, 1);
   endtask

   task automatic t_fmt_b();
      int bad, nsync, k;
      do_start(1'b1, 8'd0);
      fmt_sel = 1'b0;
      gaps = 1; // R7: idle cycles between bits
      rec_cnt = 0;
      for (int i = 0; i < 5; i++) send_bit(1'b0);
      for (int f = 0; f < 5; f++) send_frame(1'b1, f, 1'b0);
      gaps = 0;
      idle(); idle();
      chk(locked == 1, "R3 lock fmt B with gaps (R7)", locked, 1);
      chk(rec_cnt == 438, "R2 sync dropped, count", rec_cnt, 438);
      bad = 0; nsync = 0; k = 0;
      for (int f = 2; f <= 4; f++)
         for (int i = 1; i < 147; i++) begin
            if (k < rec_cnt) begin
               if (rec_b[k] != pay(f, i)) bad++;
               if (rec_s[k] != (i == 1)) bad++;
               if (rec_y[k]) nsync++;
            end
            k++;
         end
      chk(bad == 0, "R2 payload and sob on byte 1", bad, 0);
      chk(nsync == 0, "R2 sync flag never set", nsync, 0);
   endtask

   task automatic t_loss();
      do_start(1'b0, 8'd0);
      for (int i = 0; i < 7; i++) send_bit(1'b0);
      for (int f = 0; f < 3; f++) send_frame(1'b0, f, 1'b0);
      idle(); idle();
      chk(locked == 1, "R4 locked before misses", locked, 1);
      rec_cnt = 0;
      for (int f = 3; f < 6; f++) send_frame(1'b0, f, 1'b1);
      idle();
      chk(locked == 1, "R4 three misses keep lock", locked, 1);
      chk(rec_b[0] == 8'h00 && rec_s[0] == 1 && rec_y[0] == 0,
          "R4 missed sync output with sob only", {rec_b[0], rec_s[0], rec_y[0]}, 2);
      send_frame(1'b0, 6, 1'b0);
      for (int f = 7; f < 10; f++) send_frame(1'b0, f, 1'b1);
      idle();
      chk(locked == 1, "R4 good sync resets miss run", locked, 1);
      send_byte(8'h00);
      idle();
      chk(locked == 0, "R4 lock lost on fourth miss", locked, 0);
      for (int i = 1; i < 204; i++) send_byte(pay(10, i));
      send_frame(1'b0, 11, 1'b0);
      send_frame(1'b0, 12, 1'b0);
      send_byte(8'h47);
      idle();
      chk(locked == 1, "R4 relock after new search", locked, 1);
   endtask

   task automatic t_fail();
      do_start(1'b0, 8'd3);
      for (int i = 0; i < 4895; i++) send_bit(1'b0);
      idle();
      chk(fail == 0, "R5 no fail before limit", fail, 0);
      send_bit(1'b0);
      idle();
      chk(fail == 1 && locked == 0, "R5 fail at limit", fail, 1);
      rec_cnt = 0;
      for (int f = 0; f < 4; f++) send_frame(1'b0, f, 1'b0);
      idle(); idle();
      chk(locked == 0 && fail == 1, "R5 search halted after fail", {locked, fail}, 1);
      chk(rec_cnt == 0, "R5 no bytes after fail", rec_cnt, 0);
      do_start(1'b0, 8'd0);
      for (int i = 0; i < 5 * 1632; i++) send_bit(1'b0);
      idle();
      chk(fail == 0, "R5 limit zero never fails", fail, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fmt_a();
      t_fmt_b();
      t_loss();
      t_fail();
      repeat (3) @(negedge clk);
      summary();
   end
endmodule